// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block derives every timing signal a text-mode display needs from one dot-rate clock. A phase counter splits the clock into character cells of eight dots. A chain of three counters then tracks the character column within a scan line, the scan line within a character row, and the character row within a frame. From those counts the block decodes horizontal and vertical blanking, the horizontal and vertical drive pulses, a display-active flag, and the address of the display-memory byte that belongs to the current cell.

Two static inputs choose the variant. `narrow_mode` selects the wide-character (32-column) layout. In that layout the dot shift enable and the character latch strobe run at half rate, and only even cells are fetched. The line length and the counters are the same as in the 64-column layout. `std_50hz` lengthens the frame from 22 to 26 character rows. All strobes are one-clock enables in the dot clock domain, and the block creates no derived clocks.

Top module: `char_raster_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the column, line and row counters and the dot phase. The first clock after `rst` is released starts character cell 0 of line 0 of row 0.
- R2: When `narrow_mode`=0, `shift_en` is high on every clock. `latch_stb` is high for exactly one clock in every 8, on the first dot of each cell.
- R3: When `narrow_mode`=1, `shift_en` is high on odd dots only (8 per 16 clocks). `latch_stb` is high only on the first dot of cells whose column is even. A line still lasts 80 × 8 clocks.
- R4: `col_count` advances once per 8 clocks and wraps from 79 to 0.
- R5: `line_count` advances when the column wraps and counts modulo `LINES_PER_ROW` (default 12).
- R6: `row_count` advances when the line counter wraps. It counts modulo `ROWS_60` (default 22) when `std_50hz`=0 and modulo `ROWS_50` (default 26) when `std_50hz`=1.
- R7: `hblank` is high for columns 64..79. `vblank` is high for rows at or above `ROWS_SHOWN` (default 16). `disp_en` is high only when both are low.
- R8: `hdrive` is high for columns `HD_FIRST` to `HD_FIRST+HD_LEN-1` (default 68..75). `vdrive` is high during every vertically blanked row and is low on displayed rows.
- R9: `scan_addr` carries the low row bits in its upper field and the column bits [5:0] in its lower field. Bit 0 of the address is forced to 0 when `narrow_mode`=1.
- R10: If the frame standard is changed while the row count lies beyond the new last row, the next row advance returns the row count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| narrow_mode | input | 1 | 1 = 32-column wide characters, 0 = 64 columns |
| std_50hz | input | 1 | 1 = 50 Hz frame (26 rows), 0 = 60 Hz (22 rows) |
| shift_en | output | 1 | Dot shift enable for the serializer |
| latch_stb | output | 1 | Character byte latch strobe |
| col_count | output | $clog2(COLS_TOTAL) | Character column in the line |
| line_count | output | $clog2(LINES_PER_ROW) | Scan line within the character row |
| row_count | output | $clog2(max rows) | Character row in the frame |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Active display area |
| hdrive | output | 1 | Horizontal drive pulse |
| vdrive | output | 1 | Vertical drive pulse |
| scan_addr | output | $clog2(ROWS_SHOWN)+$clog2(COLS_SHOWN) | Display-memory fetch address |

## Verification
The bench keeps the default dot and column geometry: 8 dots per cell, 80 columns per line, 64 of them shown, and the drive window at 68..75. This way every horizontal decode is checked at its real size. It reduces the vertical dimensions to 3 lines per row, 4 shown rows, and 6 or 8 total rows. A full frame then lasts 11,520 or 15,360 clocks. This makes the row wrap under both standards, the vertical drive edges, and a standard switch on a row above the new limit all reachable within a short run.

// File: rtl/char_raster_pkg.sv
package char_raster_pkg;

   typedef struct packed {
      logic hblank;
      logic vblank;
      logic hdrive;
      logic vdrive;
   } raster_flags_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/crt_dot_phase.sv
module crt_dot_phase #(
   parameter int DOTS = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic narrow_mode,
   input  logic col_even,
   output logic char_tick,
   output logic shift_en,
   output logic latch_stb
);
   import char_raster_pkg::*;

   localparam int PH_W = (DOTS > 1) ? $clog2(DOTS) : 1;

   logic [PH_W-1:0] phase_q;
   logic            phase_last;

   generate
      if (is_pow2(DOTS)) begin : g_pow2
         // natural binary wrap, no compare needed
         assign phase_last = &phase_q;
         always_ff @(posedge clk) begin
            if (rst) phase_q <= '0;
            else     phase_q <= phase_q + 1'b1;
         end
      end else begin : g_cmp
         assign phase_last = (int'(phase_q) == DOTS - 1);
         always_ff @(posedge clk) begin
            if (rst)             phase_q <= '0;
            else if (phase_last) phase_q <= '0;
            else                 phase_q <= phase_q + 1'b1;
         end
      end
   endgenerate

   assign char_tick = phase_last;
   // wide characters: shift on odd dots, two cells give DOTS shifts
   assign shift_en  = narrow_mode ? phase_q[0] : 1'b1;
   assign latch_stb = (phase_q == '0) && (!narrow_mode || col_even);

endmodule

// File: rtl/crt_mod_counter.sv
module crt_mod_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic [W-1:0] last,
   output logic [W-1:0] count,
   output logic         wrap
);
   logic [W-1:0] cnt_q;
   logic         at_end;

   // >= keeps a count that lies above a newly lowered limit bounded
   assign at_end = (cnt_q >= last);
   assign wrap   = step && at_end;

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

endmodule

// File: rtl/crt_decode.sv
module crt_decode #(
   parameter int COL_W      = 7,
   parameter int ROW_W      = 5,
   parameter int COLS_SHOWN = 64,
   parameter int ROWS_SHOWN = 16,
   parameter int HD_FIRST   = 68,
   parameter int HD_LEN     = 8,
   parameter int COL_AW     = 6,
   parameter int ROW_AW     = 4
) (
   input  logic                       narrow_mode,
   input  logic [COL_W-1:0]           col,
   input  logic [ROW_W-1:0]           row,
   output char_raster_pkg::raster_flags_t flags,
   output logic [ROW_AW+COL_AW-1:0]   addr
);
   logic col_lsb;

   always_comb begin
      flags.hblank = int'(col) >= COLS_SHOWN;
      flags.hdrive = (int'(col) >= HD_FIRST) && (int'(col) < HD_FIRST + HD_LEN);
      flags.vblank = int'(row) >= ROWS_SHOWN;
      flags.vdrive = int'(row) >= ROWS_SHOWN;
   end

   assign col_lsb = col[0] & ~narrow_mode;

   generate
      if (COL_AW > 1) begin : g_wide_col
         assign addr = {row[ROW_AW-1:0], col[COL_AW-1:1], col_lsb};
      end else begin : g_one_col
         assign addr = {row[ROW_AW-1:0], col_lsb};
      end
   endgenerate

endmodule

// File: rtl/char_raster_timer.sv
module char_raster_timer #(
   parameter int DOTS_PER_CHAR = 8,
   parameter int COLS_TOTAL    = 80,
   parameter int COLS_SHOWN    = 64,
   parameter int LINES_PER_ROW = 12,
   parameter int ROWS_60       = 22,
   parameter int ROWS_50       = 26,
   parameter int ROWS_SHOWN    = 16,
   parameter int HD_FIRST      = 68,
   parameter int HD_LEN        = 8,
   localparam int COL_W  = $clog2(COLS_TOTAL),
   localparam int LINE_W = $clog2(LINES_PER_ROW),
   localparam int ROW_W  = $clog2((ROWS_50 > ROWS_60) ? ROWS_50 : ROWS_60),
   localparam int ADDR_W = $clog2(ROWS_SHOWN) + $clog2(COLS_SHOWN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              narrow_mode,
   input  logic              std_50hz,
   output logic              shift_en,
   output logic              latch_stb,
   output logic [COL_W-1:0]  col_count,
   output logic [LINE_W-1:0] line_count,
   output logic [ROW_W-1:0]  row_count,
   output logic              hblank,
   output logic              vblank,
   output logic              disp_en,
   output logic              hdrive,
   output logic              vdrive,
   output logic [ADDR_W-1:0] scan_addr
);
   import char_raster_pkg::*;

   localparam int COL_AW = $clog2(COLS_SHOWN);
   localparam int ROW_AW = $clog2(ROWS_SHOWN);

   // elaboration-time parameter checks
   if (DOTS_PER_CHAR < 2 || (DOTS_PER_CHAR % 2) != 0) begin : g_bad_dots
      $error("DOTS_PER_CHAR must be even and at least 2");
   end
   if (!is_pow2(COLS_SHOWN) || COLS_SHOWN < 2 || COLS_SHOWN > COLS_TOTAL) begin : g_bad_cols
      $error("COLS_SHOWN must be a power of two not above COLS_TOTAL");
   end
   if ((COLS_TOTAL % 2) != 0) begin : g_bad_total
      $error("COLS_TOTAL must be even");
   end
   if (LINES_PER_ROW < 2) begin : g_bad_lines
      $error("LINES_PER_ROW must be at least 2");
   end
   if (!is_pow2(ROWS_SHOWN) || ROWS_SHOWN < 2 || ROWS_SHOWN >= ROWS_60 || ROWS_SHOWN >= ROWS_50) begin : g_bad_rows
      $error("ROWS_SHOWN must be a power of two below both frame lengths");
   end
   if (HD_LEN < 1 || HD_FIRST < COLS_SHOWN || HD_FIRST + HD_LEN > COLS_TOTAL) begin : g_bad_hd
      $error("horizontal drive window must lie inside the blanked columns");
   end

   logic             chr_tick;
   logic             col_wrap;
   logic             line_wrap;
   logic             row_wrap;
   logic [ROW_W-1:0] row_last;
   raster_flags_t    flags;

   crt_dot_phase #(.DOTS(DOTS_PER_CHAR)) u_phase (
      .clk         (clk),
      .rst         (rst),
      .narrow_mode (narrow_mode),
      .col_even    (~col_count[0]),
      .char_tick   (chr_tick),
      .shift_en    (shift_en),
      .latch_stb   (latch_stb)
   );

   crt_mod_counter #(.W(COL_W)) u_col (
      .clk   (clk),
      .rst   (rst),
      .step  (chr_tick),
      .last  (COL_W'(COLS_TOTAL - 1)),
      .count (col_count),
      .wrap  (col_wrap)
   );

   crt_mod_counter #(.W(LINE_W)) u_line (
      .clk   (clk),
      .rst   (rst),
      .step  (col_wrap),
      .last  (LINE_W'(LINES_PER_ROW - 1)),
      .count (line_count),
      .wrap  (line_wrap)
   );

   assign row_last = std_50hz ? ROW_W'(ROWS_50 - 1) : ROW_W'(ROWS_60 - 1);

   crt_mod_counter #(.W(ROW_W)) u_row (
      .clk   (clk),
      .rst   (rst),
      .step  (line_wrap),
      .last  (row_last),
      .count (row_count),
      .wrap  (row_wrap)
   );

   crt_decode #(
      .COL_W      (COL_W),
      .ROW_W      (ROW_W),
      .COLS_SHOWN (COLS_SHOWN),
      .ROWS_SHOWN (ROWS_SHOWN),
      .HD_FIRST   (HD_FIRST),
      .HD_LEN     (HD_LEN),
      .COL_AW     (COL_AW),
      .ROW_AW     (ROW_AW)
   ) u_dec (
      .narrow_mode (narrow_mode),
      .col         (col_count),
      .row         (row_count),
      .flags       (flags),
      .addr        (scan_addr)
   );

   assign hblank  = flags.hblank;
   assign vblank  = flags.vblank;
   assign hdrive  = flags.hdrive;
   assign vdrive  = flags.vdrive;
   assign disp_en = ~flags.hblank & ~flags.vblank;

   logic unused_row_wrap;
   assign unused_row_wrap = row_wrap;

endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
   parameter int COLS_TOTAL    = 80,
   parameter int COLS_SHOWN    = 64,
   parameter int LINES_PER_ROW = 12,
   parameter int ROWS_60       = 22,
   parameter int ROWS_50       = 26,
   parameter int ROWS_SHOWN    = 16,
   parameter int COL_W         = 7,
   parameter int LINE_W        = 4,
   parameter int ROW_W         = 5,
   parameter int ADDR_W        = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              narrow_mode,
   input logic              std_50hz,
   input logic              chr_tick,
   input logic              latch_stb,
   input logic [COL_W-1:0]  col_count,
   input logic [LINE_W-1:0] line_count,
   input logic [ROW_W-1:0]  row_count,
   input logic              hblank,
   input logic              vdrive,
   input logic [ADDR_W-1:0] scan_addr
);
   localparam int ROWS_MAX = (ROWS_50 > ROWS_60) ? ROWS_50 : ROWS_60;

   logic col_end, line_end, row_end;
   assign col_end  = chr_tick && (int'(col_count) == COLS_TOTAL - 1);
   assign line_end = col_end && (int'(line_count) == LINES_PER_ROW - 1);
   assign row_end  = line_end &&
                     (int'(row_count) >= (std_50hz ? ROWS_50 : ROWS_60) - 1);

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (col_count == '0 && line_count == '0 && row_count == '0));

   assert_latch_single_R2: assert property (@(posedge clk) disable iff (rst)
      latch_stb |=> !latch_stb);

   assert_col_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !chr_tick |=> $stable(col_count));

   assert_col_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      col_end |=> col_count == '0);

   assert_line_range_R5: assert property (@(posedge clk) disable iff (rst)
      int'(line_count) < LINES_PER_ROW);

   assert_line_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      line_end |=> line_count == '0);

   assert_row_range_R6: assert property (@(posedge clk) disable iff (rst)
      int'(row_count) < ROWS_MAX);

   assert_hblank_start_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(hblank) |-> int'(col_count) == COLS_SHOWN);

   assert_vdrive_start_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(vdrive) |-> (int'(row_count) == ROWS_SHOWN && col_count == '0 && line_count == '0));

   assert_addr_even_R9: assert property (@(posedge clk) disable iff (rst)
      (narrow_mode && latch_stb) |-> !scan_addr[0]);

   assert_row_return_R10: assert property (@(posedge clk) disable iff (rst)
      row_end |=> row_count == '0);

endmodule

bind char_raster_timer crt_checker #(
   .COLS_TOTAL    (COLS_TOTAL),
   .COLS_SHOWN    (COLS_SHOWN),
   .LINES_PER_ROW (LINES_PER_ROW),
   .ROWS_60       (ROWS_60),
   .ROWS_50       (ROWS_50),
   .ROWS_SHOWN    (ROWS_SHOWN),
   .COL_W         (COL_W),
   .LINE_W        (LINE_W),
   .ROW_W         (ROW_W),
   .ADDR_W        (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .narrow_mode (narrow_mode),
   .std_50hz    (std_50hz),
   .chr_tick    (chr_tick),
   .latch_stb   (latch_stb),
   .col_count   (col_count),
   .line_count  (line_count),
   .row_count   (row_count),
   .hblank      (hblank),
   .vdrive      (vdrive),
   .scan_addr   (scan_addr)
);

// File: tb/char_raster_timer_bench.sv
module char_raster_timer_bench;

   localparam int DOTS = 8;
   localparam int CT   = 80;
   localparam int CS   = 64;
   localparam int LPR  = 3;
   localparam int R60  = 6;
   localparam int R50  = 8;
   localparam int RS   = 4;
   localparam int HDF  = 68;
   localparam int HDL  = 8;
   localparam int LINE_CLK = DOTS * CT;
   localparam int COL_W  = $clog2(CT);
   localparam int LINE_W = $clog2(LPR);
   localparam int ROW_W  = $clog2(R50);
   localparam int ADDR_W = $clog2(RS) + $clog2(CS);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic narrow_mode = 1'b0;
   logic std_50hz = 1'b0;
   logic shift_en, latch_stb, hblank, vblank, disp_en, hdrive, vdrive;
   logic [COL_W-1:0]  col_count;
   logic [LINE_W-1:0] line_count;
   logic [ROW_W-1:0]  row_count;
   logic [ADDR_W-1:0] scan_addr;

   int total = 0;
   int bad   = 0;
   int k     = 0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (rst) k <= 0;
      else     k <= k + 1;
   end

   char_raster_timer #(
      .DOTS_PER_CHAR (DOTS), .COLS_TOTAL (CT), .COLS_SHOWN (CS),
      .LINES_PER_ROW (LPR), .ROWS_60 (R60), .ROWS_50 (R50),
      .ROWS_SHOWN (RS), .HD_FIRST (HDF), .HD_LEN (HDL)
   ) u_char_raster_timer (
      .clk (clk), .rst (rst), .narrow_mode (narrow_mode), .std_50hz (std_50hz),
      .shift_en (shift_en), .latch_stb (latch_stb), .col_count (col_count),
      .line_count (line_count), .row_count (row_count), .hblank (hblank),
      .vblank (vblank), .disp_en (disp_en), .hdrive (hdrive), .vdrive (vdrive),
      .scan_addr (scan_addr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d (k=%0d)", req, what, act, exp, k);
      end
   endtask

   task automatic do_reset(input logic nm, input logic s50);
      @(negedge clk);
      rst = 1'b1;
      narrow_mode = nm;
      std_50hz = s50;
      repeat (3) @(negedge clk);
      chk("R1", "col in reset", int'(col_count), 0);
      chk("R1", "line in reset", int'(line_count), 0);
      chk("R1", "row in reset", int'(row_count), 0);
      rst = 1'b0;
   endtask

   // expected outputs from the clock count since reset release
   task automatic check_all();
      int dot  = k % DOTS;
      int col  = (k / DOTS) % CT;
      int lns  = k / LINE_CLK;
      int line = lns % LPR;
      int row  = (lns / LPR) % (std_50hz ? R50 : R60);
      int addr = (row % RS) * CS + (col % CS);
      if (narrow_mode) addr = addr & ~1;
      chk("R4", "col", int'(col_count), col);
      chk("R5", "line", int'(line_count), line);
      chk("R6", "row", int'(row_count), row);
      chk(narrow_mode ? "R3" : "R2", "shift_en", int'(shift_en),
          narrow_mode ? ((dot % 2) == 1 ? 1 : 0) : 1);
      chk(narrow_mode ? "R3" : "R2", "latch_stb", int'(latch_stb),
          (dot == 0 && (!narrow_mode || (col % 2) == 0)) ? 1 : 0);
      chk("R7", "hblank", int'(hblank), (col >= CS) ? 1 : 0);
      chk("R7", "vblank", int'(vblank), (row >= RS) ? 1 : 0);
      chk("R7", "disp_en", int'(disp_en), (col < CS && row < RS) ? 1 : 0);
      chk("R8", "hdrive", int'(hdrive), (col >= HDF && col < HDF + HDL) ? 1 : 0);
      chk("R8", "vdrive", int'(vdrive), (row >= RS) ? 1 : 0);
      chk("R9", "scan_addr", int'(scan_addr), addr);
   endtask

   task automatic run_frame(input logic nm, input logic s50);
      int n = LINE_CLK * LPR * (s50 ? R50 : R60) + 2 * LINE_CLK;
      do_reset(nm, s50);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_all();
      end
   endtask

   task automatic count_strobes(input logic nm);
      int nl = 0;
      int ns = 0;
      do_reset(nm, 1'b0);
      for (int i = 0; i < LINE_CLK; i++) begin
         @(negedge clk);
         nl += int'(latch_stb);
         ns += int'(shift_en);
      end
      chk(nm ? "R3" : "R2", "latches per line", nl, nm ? CT / 2 : CT);
      chk(nm ? "R3" : "R2", "shifts per line", ns, nm ? LINE_CLK / 2 : LINE_CLK);
      chk(nm ? "R3" : "R2", "line length back at col 0", int'(col_count), 0);
      chk(nm ? "R3" : "R2", "next line started", int'(line_count), 1);
   endtask

   task automatic std_switch();
      do_reset(1'b0, 1'b1);
      for (int i = 0; i < LINE_CLK * LPR * (R50 - 1); i++) @(negedge clk);
      chk("R10", "row before switch", int'(row_count), R50 - 1);
      std_50hz = 1'b0;
      for (int i = 0; i < LINE_CLK * LPR - 1; i++) @(negedge clk);
      chk("R10", "row held until advance", int'(row_count), R50 - 1);
      @(negedge clk);
      chk("R10", "row after advance", int'(row_count), 0);
      chk("R10", "line after advance", int'(line_count), 0);
   endtask

   task automatic mid_reset();
      do_reset(1'b0, 1'b0);
      for (int i = 0; i < LINE_CLK * LPR + 3 * DOTS + 5; i++) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1", "col after mid reset", int'(col_count), 0);
      chk("R1", "line after mid reset", int'(line_count), 0);
      chk("R1", "row after mid reset", int'(row_count), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "restart col", int'(col_count), 0);
      chk("R1", "restart latch", int'(latch_stb), 0);
   endtask

   initial begin
      count_strobes(1'b0);
      count_strobes(1'b1);
      run_frame(1'b0, 1'b0);
      run_frame(1'b1, 1'b1);
      std_switch();
      mid_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule